// File: doc/BRIEF.md
# Audio Master Clock Divider

This block takes the audio master clock and derives three timing signals from it. All three are clock enables that run in the master clock domain. The core enable marks the cycles that make up the internal core clock. The clock-output enable marks the cycles of a secondary clock that is passed to the pins. The frame strobe is a one-cycle pulse that fires once per audio sample period.

Two divide-by-two stages are chained and each has its own control bit. The first stage divides the master clock into the core clock. The second stage divides the core clock into the clock output. An oversampling ratio sets how many core cycles make up one sample period. That ratio depends on two inputs: a mode bit, which says whether the master clock is a standard audio multiple or a fixed USB-style clock, and a ratio-select bit.

A 4-bit sample-rate code travels with the configuration. The block holds it so that later rate-scaling logic can use it. Whenever any configuration input changes, every divider phase and the frame counter restart from a clean state.

Top module: `audio_mclk_divider`

## Requirements
- R1: While rst_ni is low, and for the first cycle after its release, core_en_o, clkout_en_o and frame_stb_o are all 0. The reset is released through a two-flop synchronizer, so the second rising edge after release is the first one at which outputs may go active.
- R2: With core_half_i = 0, core_en_o is 1 on every master clock cycle once running.
- R3: With core_half_i = 1, core_en_o is 1 on every second cycle. It is 0 in the first running cycle (cycle index 0) and 1 at index 1.
- R4: With out_half_i = 0, clkout_en_o equals core_en_o on every cycle.
- R5: With out_half_i = 1, clkout_en_o is 1 only on every second core pulse, starting with the second one (core pulse index 1), and it is never 1 without core_en_o.
- R6: With usb_mode_i = 0, a sample period is 256 core pulses when osr_sel_i = 0 and 384 when osr_sel_i = 1.
- R7: With usb_mode_i = 1, a sample period is 250 core pulses when osr_sel_i = 0 and 272 when osr_sel_i = 1.
- R8: frame_stb_o is a single-cycle pulse that coincides with core_en_o on the N-th core pulse of each period. With d = 2 when core_half_i = 1 and d = 1 otherwise, the first pulse falls at running cycle index N*d-1 and the pulses then repeat every N*d cycles.
- R9: A change on any configuration input (including rate_code_i) that is seen at a rising edge restarts both divider phases and the frame count, so the cycle after that edge is running cycle index 0.
- R10: rate_code_o holds the value of rate_code_i from the previous cycle. It reads 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| core_half_i | input | 1 | Divide master clock by two for the core |
| out_half_i | input | 1 | Divide core clock by two for the clock output |
| usb_mode_i | input | 1 | 0: audio-multiple master clock, 1: USB-style clock |
| osr_sel_i | input | 1 | Selects the alternate oversampling ratio |
| rate_code_i | input | 4 | Sample-rate code to hold |
| core_en_o | output | 1 | Core clock enable |
| clkout_en_o | output | 1 | Clock output enable |
| frame_stb_o | output | 1 | One-cycle strobe per sample period |
| rate_code_o | output | 4 | Held sample-rate code |

## Verification
The bench sweeps all four oversampling ratios and every combination of the two halving stages. For each setting it measures the first and second strobe positions and counts the core and output pulses between them. A counter off by one would move the strobe by one core period, and a wrong ratio decode would give a pulse count of 256 in USB mode. A halving stage that starts in the wrong phase would put the first core or output pulse one cycle early. A changed rate code is applied in the middle of a frame: if the design does not restart, its next strobe lands at the old frame position instead of exactly 256 cycles later. The bench also checks the two-cycle reset release, because a missing synchronizer stage makes the outputs go active one cycle early.

// File: rtl/amd_pkg.sv
package amd_pkg;

  localparam int unsigned RATE_W = 4;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              usb;
    logic              osr;
    logic              core_half;
    logic              out_half;
  } amd_cfg_t;

  // Core cycles per sample period for a given mode and ratio select.
  function automatic int unsigned amd_ratio(
    input logic        usb,
    input logic        osr,
    input int unsigned norm_base,
    input int unsigned norm_alt,
    input int unsigned usb_base,
    input int unsigned usb_alt
  );
    if (usb) return osr ? usb_alt : usb_base;
    return osr ? norm_alt : norm_base;
  endfunction

endpackage

// File: rtl/amd_reset_sync.sv
module amd_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic run_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign run_o = sync_q[STAGES-1];

endmodule

// File: rtl/amd_half_stage.sv
module amd_half_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  input  logic en_i,
  input  logic half_i,
  output logic en_o
);

  logic ph_q;
  logic ph_d;

  always_comb begin
    ph_d = ph_q;
    if (!run_i || clr_i)    ph_d = 1'b0;
    else if (en_i && half_i) ph_d = ~ph_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ph_d;
  end

  assign en_o = run_i & en_i & (half_i ? ph_q : 1'b1);

  // R3 and R5: a halving stage never gives two pulses back to back.
  assert_half_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_i && en_o && !clr_i) |=> !en_o);

endmodule

// File: rtl/amd_frame_count.sv
module amd_frame_count #(
  parameter int unsigned NORM_BASE = 256,
  parameter int unsigned NORM_ALT  = 384,
  parameter int unsigned USB_BASE  = 250,
  parameter int unsigned USB_ALT   = 272,
  parameter int unsigned CNT_W     = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  input  logic core_en_i,
  input  logic usb_i,
  input  logic osr_i,
  output logic stb_o
);
  import amd_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last_val;
  logic             at_last;

  always_comb begin
    last_val = CNT_W'(amd_ratio(usb_i, osr_i, NORM_BASE, NORM_ALT,
                                USB_BASE, USB_ALT) - 1);
    at_last  = (cnt_q == last_val);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || clr_i) cnt_d = '0;
    else if (core_en_i)  cnt_d = at_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign stb_o = run_i & core_en_i & at_last;

  // R8: the count stays inside the selected period.
  assert_cnt_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_val);
  // R8: the strobe lasts one cycle.
  assert_stb_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);
  // R8: after the strobe, the period starts again from zero.
  assert_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_o && !clr_i) |=> (cnt_q == '0));
  // R9: a configuration change restarts the count.
  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/audio_mclk_divider.sv
module audio_mclk_divider #(
  parameter int unsigned NORM_BASE = 256,
  parameter int unsigned NORM_ALT  = 384,
  parameter int unsigned USB_BASE  = 250,
  parameter int unsigned USB_ALT   = 272
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       core_half_i,
  input  logic                       out_half_i,
  input  logic                       usb_mode_i,
  input  logic                       osr_sel_i,
  input  logic [amd_pkg::RATE_W-1:0] rate_code_i,
  output logic                       core_en_o,
  output logic                       clkout_en_o,
  output logic                       frame_stb_o,
  output logic [amd_pkg::RATE_W-1:0] rate_code_o
);
  import amd_pkg::*;

  localparam int unsigned MAX_AB  = (NORM_BASE > NORM_ALT) ? NORM_BASE : NORM_ALT;
  localparam int unsigned MAX_CD  = (USB_BASE > USB_ALT) ? USB_BASE : USB_ALT;
  localparam int unsigned MAX_N   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int unsigned CNT_W   = $clog2(MAX_N);
  localparam int unsigned N_HALF  = 2;

  logic     run;
  amd_cfg_t cfg_in;
  amd_cfg_t cfg_q;
  logic     chg;

  amd_reset_sync #(.STAGES(2)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_o (run)
  );

  always_comb begin
    cfg_in.rate      = rate_code_i;
    cfg_in.usb       = usb_mode_i;
    cfg_in.osr       = osr_sel_i;
    cfg_in.core_half = core_half_i;
    cfg_in.out_half  = out_half_i;
    chg              = (cfg_in != cfg_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_in;
  end

  // Two chained halving stages: master -> core -> clock output.
  logic [N_HALF:0]   en_chain;
  logic [N_HALF-1:0] half_sel;

  assign en_chain[0] = run;
  assign half_sel    = {cfg_q.out_half, cfg_q.core_half};

  for (genvar g = 0; g < N_HALF; g++) begin : g_half
    amd_half_stage u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (run),
      .clr_i (chg),
      .en_i  (en_chain[g]),
      .half_i(half_sel[g]),
      .en_o  (en_chain[g+1])
    );
  end

  assign core_en_o   = en_chain[1];
  assign clkout_en_o = en_chain[2];

  amd_frame_count #(
    .NORM_BASE(NORM_BASE),
    .NORM_ALT (NORM_ALT),
    .USB_BASE (USB_BASE),
    .USB_ALT  (USB_ALT),
    .CNT_W    (CNT_W)
  ) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .clr_i    (chg),
    .core_en_i(core_en_o),
    .usb_i    (cfg_q.usb),
    .osr_i    (cfg_q.osr),
    .stb_o    (frame_stb_o)
  );

  assign rate_code_o = cfg_q.rate;

  // R1: nothing is active until the synchronized reset has been released.
  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (!core_en_o && !clkout_en_o && !frame_stb_o));
  // R2: without the core halving, every running cycle is a core cycle.
  assert_core_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !cfg_q.core_half && !chg) |=> core_en_o);
  // R5: the output enable is a subset of the core enable.
  assert_out_sub_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clkout_en_o |-> core_en_o);
  // R8: the strobe lands on a core cycle.
  assert_stb_core_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_o |-> core_en_o);
  // R10: the held code follows the input with one cycle of delay.
  assert_rate_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> (rate_code_o == $past(rate_code_i)));

endmodule

// File: tb/audio_mclk_divider_test.sv
module audio_mclk_divider_test;

  logic       clk;
  logic       rst_n;
  logic       core_half, out_half, usb_mode, osr_sel;
  logic [3:0] rate_code;
  logic       core_en, clkout_en, frame_stb;
  logic [3:0] rate_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  audio_mclk_divider uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .core_half_i(core_half),
    .out_half_i (out_half),
    .usb_mode_i (usb_mode),
    .osr_sel_i  (osr_sel),
    .rate_code_i(rate_code),
    .core_en_o  (core_en),
    .clkout_en_o(clkout_en),
    .frame_stb_o(frame_stb),
    .rate_code_o(rate_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ratio_of(input logic usb, input logic osr);
    if (usb) return osr ? 272 : 250;
    return osr ? 384 : 256;
  endfunction

  // Reset held, then released; R1 and the R10 reset value.
  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    core_half = 0; out_half = 0; usb_mode = 0; osr_sel = 0; rate_code = 4'd0;
    repeat (3) @(negedge clk);
    check(!core_en && !clkout_en && !frame_stb, "R1 outputs idle in reset",
          {core_en, clkout_en, frame_stb}, 0);
    check(rate_out == 4'd0, "R10 reset code", rate_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!core_en && !clkout_en && !frame_stb, "R1 idle first cycle after release",
          {core_en, clkout_en, frame_stb}, 0);
    @(negedge clk);
    check(core_en == 1'b1, "R1 active second cycle after release", core_en, 1);
  endtask

  // Applies a configuration (the rate code always differs, so R9 restarts)
  // and measures two full sample periods.
  task automatic t_frame(input logic usb, input logic osr, input logic ch,
                         input logic oh, input logic [3:0] rc);
    int n, d, s1, s2, ncore, nout, pidx, core_bad, out_bad, stb_bad;
    n = ratio_of(usb, osr);
    d = ch ? 2 : 1;
    s1 = -1; s2 = -1; ncore = 0; nout = 0; pidx = 0;
    core_bad = 0; out_bad = 0; stb_bad = 0;
    @(negedge clk);
    usb_mode = usb; osr_sel = osr; core_half = ch; out_half = oh; rate_code = rc;
    @(posedge clk);
    for (int k = 0; k < 2 * n * d + 2; k++) begin
      logic exp_core, exp_out;
      @(negedge clk);
      if (k == 0) check(rate_out == rc, "R10 code held", rate_out, rc);
      exp_core = ch ? (k % 2 == 1) : 1'b1;
      exp_out  = exp_core && (oh ? (pidx % 2 == 1) : 1'b1);
      if (core_en !== exp_core) core_bad++;
      if (clkout_en !== exp_out) out_bad++;
      if (frame_stb && !core_en) stb_bad++;
      if (s1 >= 0 && s2 < 0) begin
        if (core_en) ncore++;
        if (clkout_en) nout++;
      end
      if (frame_stb) begin
        if (s1 < 0) s1 = k;
        else if (s2 < 0) s2 = k;
      end
      if (core_en) pidx++;
    end
    if (ch) check(core_bad == 0, "R3 core pattern halved", core_bad, 0);
    else    check(core_bad == 0, "R2 core every cycle", core_bad, 0);
    if (oh) check(out_bad == 0, "R5 output pattern halved", out_bad, 0);
    else    check(out_bad == 0, "R4 output equals core", out_bad, 0);
    check(stb_bad == 0, "R8 strobe on core cycle", stb_bad, 0);
    check(s1 == n * d - 1, "R8 first strobe position", s1, n * d - 1);
    check(s2 - s1 == n * d, "R8 strobe spacing", s2 - s1, n * d);
    if (usb) check(ncore == n, "R7 usb core pulses per period", ncore, n);
    else     check(ncore == n, "R6 normal core pulses per period", ncore, n);
    check(nout == n / (oh ? 2 : 1), "R5 output pulses per period", nout, n / (oh ? 2 : 1));
  endtask

  // A change in the middle of a period restarts the count (R9).
  task automatic t_midchange();
    int pos;
    t_frame(1'b0, 1'b0, 1'b0, 1'b0, 4'd9);
    repeat (100) @(negedge clk);
    rate_code = 4'd10;
    @(posedge clk);
    pos = -1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (frame_stb && pos < 0) pos = k;
    end
    check(pos == 255, "R9 restart after change", pos, 255);
  endtask

  // A reset pulse in mid-run silences every output (R1).
  task automatic t_reset_mid();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!core_en && !clkout_en && !frame_stb, "R1 idle on mid-run reset",
          {core_en, clkout_en, frame_stb}, 0);
    check(rate_out == 4'd0, "R10 code cleared by reset", rate_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!core_en, "R1 idle first cycle after second release", core_en, 0);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    core_half = 0; out_half = 0; usb_mode = 0; osr_sel = 0; rate_code = 4'd0;
    t_reset();
    t_frame(1'b0, 1'b0, 1'b0, 1'b0, 4'd1);
    t_frame(1'b0, 1'b1, 1'b0, 1'b0, 4'd2);
    t_frame(1'b1, 1'b0, 1'b0, 1'b0, 4'd3);
    t_frame(1'b1, 1'b1, 1'b0, 1'b0, 4'd4);
    t_frame(1'b0, 1'b0, 1'b1, 1'b0, 4'd5);
    t_frame(1'b0, 1'b0, 1'b0, 1'b1, 4'd6);
    t_frame(1'b1, 1'b1, 1'b1, 1'b1, 4'd7);
    t_frame(1'b1, 1'b0, 1'b1, 1'b0, 4'd8);
    t_frame(1'b0, 1'b1, 1'b1, 1'b1, 4'd15);
    t_midchange();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule